// File: doc/BRIEF.md
# Dual-Channel Decimating FIR Filter

This block is the second decimation stage of a stereo converter's digital path. Left and right samples arrive together, one pair per input strobe, from a comb decimator running at four times the final output rate. The block applies a 121-tap linear-phase filter and keeps one result in four. Each result is rounded and clipped to 16-bit two's complement, and both channels are presented together on a one-cycle output strobe. The filter's coefficients flatten the comb stage's droop and set the stopband.

Each channel has one time-shared multiply-accumulate lane. Because the coefficients are symmetric, mirrored history samples are added before the multiply, so a result costs 61 products per channel. Both channels share one history RAM, with one write port and two read ports, and one coefficient ROM. A select input chooses one of two coefficient banks: one suits a 48 kHz output rate and the other a 44.1 kHz rate. The select is captured only when an output computation starts.

Top module: `fir_dec_top`

## Requirements
- R1: During reset and after it ends, out_valid is 0 and out_left and out_right are 0 until the first result.
- R2: out_valid pulses for exactly one cycle once per four accepted input strobes (in_valid high at a clock edge). The first pulse follows the fourth strobe after reset, and no other pulses occur.
- R3: The result for a channel is y = sum over j=0..120 of c[j]*x[n-j], where x[n] is the sample taken by the fourth strobe, x[n-1] the one before, and so on. The coefficients are symmetric, c[j] = c[120-j]. For j ≤ 60, bank 0 uses c[j] = 8*(j+1) and bank 1 uses c[j] = 600 - 9*j.
- R4: History positions that lie before the first strobe after reset contribute zero.
- R5: The sum is rounded by adding 2^14 and then shifted right arithmetically by 15.
- R6: A rounded value above 32767 gives 32767, and one below -32768 gives -32768.
- R7: The bank is taken from fsel (0 selects bank 0, 1 selects bank 1) at the edge of the fourth strobe. Changes to fsel at any other time have no effect on that result.
- R8: The two channels are filtered independently with the same coefficients, from the samples taken by the same strobes. Both results appear in the same out_valid pulse, with left in_left → out_left and right in_right → out_right.
- R9: out_valid rises 65 clock edges after the edge that took the fourth strobe.
- R10: out_left and out_right hold their value in every cycle without an out_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 16 | Left sample, signed |
| in_right | input | 16 | Right sample, signed |
| fsel | input | 1 | Coefficient bank select |
| out_valid | output | 1 | Result strobe |
| out_left | output | 16 | Left result, signed |
| out_right | output | 16 | Right result, signed |

## Verification
The checker assumes that each fourth strobe arrives only after the previous computation has delivered its result. In practice this means that four consecutive strobes span more than 65 cycles. The input-rate assertion flags any violation. The stimulus spaces strobes at least 24 cycles apart, with random gaps of 24 to 40 cycles. The one directed short gap follows a fourth strobe, and a long idle period follows it before the next group. This keeps every group of four well beyond the computation window.

// File: rtl/fir_dec_pkg.sv
package fir_dec_pkg;

  // Coefficient value of half-index h (0 = outermost tap pair) in a bank.
  function automatic int coef_fn(input logic bank, input int h);
    int v;
    if (bank) v = 600 - 9 * h;
    else      v = 8 * (h + 1);
    return v;
  endfunction

endpackage

// File: rtl/fir_dec_hist.sv
module fir_dec_hist #(
  parameter int AW = 7,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [WW-1:0] wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [WW-1:0] qa,
  output logic [WW-1:0] qb
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    qa <= mem[ra];
    qb <= mem[rb];
  end
endmodule

// File: rtl/fir_dec_coef.sv
module fir_dec_coef #(
  parameter int CW   = 16,
  parameter int HALF = 61,
  parameter int CAW  = 7
) (
  input  logic                 clk,
  input  logic [CAW-1:0]       addr,
  output logic signed [CW-1:0] q
);
  logic signed [CW-1:0] rom [2*HALF];

  initial begin
    for (int i = 0; i < 2 * HALF; i++) begin
      if (i < HALF) rom[i] = CW'(fir_dec_pkg::coef_fn(1'b0, i));
      else          rom[i] = CW'(fir_dec_pkg::coef_fn(1'b1, i - HALF));
    end
  end

  always_ff @(posedge clk) q <= rom[addr];
endmodule

// File: rtl/fir_dec_ctrl.sv
module fir_dec_ctrl #(
  parameter int NTAPS = 121,
  parameter int DECIM = 4,
  parameter int AW    = 7,
  parameter int HW    = 6,
  parameter int CAW   = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           fsel,
  output logic [AW-1:0]  wr_addr,
  output logic [AW-1:0]  addr_a,
  output logic [AW-1:0]  addr_b,
  output logic [CAW-1:0] coef_addr,
  output logic           iss_valid,
  output logic           iss_first,
  output logic           iss_last,
  output logic           iss_use_a,
  output logic           iss_use_b
);
  localparam int HALF = (NTAPS + 1) / 2;
  localparam int PW   = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int FW   = $clog2(NTAPS + 1);

  logic [PW-1:0] phase;
  logic [AW-1:0] wptr, base;
  logic [FW-1:0] fill, fill_l, fill_inc, age_b;
  logic [HW-1:0] h;
  logic          busy, bank_l, start;

  assign start    = in_valid && (phase == PW'(DECIM - 1));
  assign fill_inc = (fill == FW'(NTAPS)) ? fill : fill + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      wptr   <= '0;
      fill   <= '0;
      busy   <= 1'b0;
      h      <= '0;
      base   <= '0;
      fill_l <= '0;
      bank_l <= 1'b0;
    end else begin
      if (in_valid) begin
        wptr  <= wptr + 1'b1;
        phase <= start ? '0 : phase + 1'b1;
        fill  <= fill_inc;
      end
      if (start) begin
        busy   <= 1'b1;
        h      <= '0;
        base   <= wptr;
        fill_l <= fill_inc;
        bank_l <= fsel;
      end else if (busy) begin
        h <= h + 1'b1;
        if (h == HW'(HALF - 1)) busy <= 1'b0;
      end
    end
  end

  assign age_b     = FW'(NTAPS - 1) - FW'(h);
  assign wr_addr   = wptr;
  assign addr_a    = base - AW'(h);
  assign addr_b    = base - AW'(NTAPS - 1) + AW'(h);
  assign coef_addr = bank_l ? CAW'(HALF) + CAW'(h) : CAW'(h);
  assign iss_valid = busy;
  assign iss_first = (h == '0);
  assign iss_last  = (h == HW'(HALF - 1));
  assign iss_use_a = FW'(h) < fill_l;
  assign iss_use_b = (age_b < fill_l) && !iss_last;
endmodule

// File: rtl/fir_dec_lane.sv
module fir_dec_lane #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int HALF  = 61,
  parameter int SHIFT = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic                 first_in,
  input  logic                 last_in,
  input  logic                 use_a,
  input  logic                 use_b,
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] res,
  output logic                 res_v
);
  localparam int PW   = DW + 1;
  localparam int MW   = PW + CW;
  localparam int ACCW = MW + $clog2(HALF);
  localparam logic signed [ACCW-1:0] SAT_HI = (ACCW'(1) <<< (DW - 1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] SAT_LO = -(ACCW'(1) <<< (DW - 1));
  localparam logic signed [ACCW-1:0] HALF_LSB = ACCW'(1) <<< (SHIFT - 1);

  logic signed [PW-1:0]   ea, eb, pre;
  logic signed [CW-1:0]   coef2;
  logic signed [MW-1:0]   prod;
  logic signed [ACCW-1:0] acc, rnd, shf;
  logic v2, f2, l2, v3, f3, l3, done;

  assign ea = use_a ? $signed({a[DW-1], a}) : '0;
  assign eb = use_b ? $signed({b[DW-1], b}) : '0;

  always_ff @(posedge clk) begin
    pre   <= ea + eb;
    coef2 <= coef;
    prod  <= pre * coef2;
    if (v3) acc <= f3 ? {{(ACCW-MW){prod[MW-1]}}, prod}
                      : acc + {{(ACCW-MW){prod[MW-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; f2 <= 1'b0; l2 <= 1'b0;
      v3 <= 1'b0; f3 <= 1'b0; l3 <= 1'b0;
      done  <= 1'b0;
      res   <= '0;
      res_v <= 1'b0;
    end else begin
      v2 <= v_in; f2 <= first_in; l2 <= last_in;
      v3 <= v2;   f3 <= f2;       l3 <= l2;
      done  <= v3 && l3;
      res_v <= done;
      if (done) begin
        if (shf > SAT_HI)      res <= DW'(SAT_HI);
        else if (shf < SAT_LO) res <= DW'(SAT_LO);
        else                   res <= DW'(shf);
      end
    end
  end

  assign rnd = acc + HALF_LSB;
  assign shf = rnd >>> SHIFT;
endmodule

// File: rtl/fir_dec_top.sv
module fir_dec_top #(
  parameter int NTAPS = 121,
  parameter int DECIM = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int SHIFT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  input  logic          fsel,
  output logic          out_valid,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right
);
  localparam int NCH  = 2;
  localparam int HALF = (NTAPS + 1) / 2;
  localparam int AW   = $clog2(NTAPS + DECIM);
  localparam int HW   = $clog2(HALF);
  localparam int CAW  = $clog2(2 * HALF);
  localparam int WW   = NCH * DW;

  logic [AW-1:0]        wr_addr, addr_a, addr_b;
  logic [CAW-1:0]       coef_addr;
  logic                 iss_v, iss_f, iss_l, iss_ua, iss_ub;
  logic                 s1_v, s1_f, s1_l, s1_ua, s1_ub;
  logic [WW-1:0]        qa, qb;
  logic signed [CW-1:0] coef_q;
  logic signed [DW-1:0] res [NCH];
  logic [NCH-1:0]       res_v;

  fir_dec_ctrl #(.NTAPS(NTAPS), .DECIM(DECIM), .AW(AW), .HW(HW), .CAW(CAW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fsel(fsel),
    .wr_addr(wr_addr), .addr_a(addr_a), .addr_b(addr_b), .coef_addr(coef_addr),
    .iss_valid(iss_v), .iss_first(iss_f), .iss_last(iss_l),
    .iss_use_a(iss_ua), .iss_use_b(iss_ub)
  );

  fir_dec_hist #(.AW(AW), .WW(WW)) u_hist (
    .clk(clk), .we(in_valid), .wa(wr_addr), .wd({in_right, in_left}),
    .ra(addr_a), .rb(addr_b), .qa(qa), .qb(qb)
  );

  fir_dec_coef #(.CW(CW), .HALF(HALF), .CAW(CAW)) u_coef (
    .clk(clk), .addr(coef_addr), .q(coef_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_f <= 1'b0; s1_l <= 1'b0; s1_ua <= 1'b0; s1_ub <= 1'b0;
    end else begin
      s1_v <= iss_v; s1_f <= iss_f; s1_l <= iss_l; s1_ua <= iss_ua; s1_ub <= iss_ub;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    fir_dec_lane #(.DW(DW), .CW(CW), .HALF(HALF), .SHIFT(SHIFT)) u_lane (
      .clk(clk), .rst(rst), .v_in(s1_v), .first_in(s1_f), .last_in(s1_l),
      .use_a(s1_ua), .use_b(s1_ub),
      .a(qa[ch*DW +: DW]), .b(qb[ch*DW +: DW]), .coef(coef_q),
      .res(res[ch]), .res_v(res_v[ch])
    );
  end

  assign out_valid = &res_v;
  assign out_left  = res[0];
  assign out_right = res[1];
endmodule

// File: rtl/fir_dec_chk.sv
module fir_dec_chk #(
  parameter int NTAPS = 121,
  parameter int DECIM = 4,
  parameter int DW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_left,
  input logic [DW-1:0] out_right
);
  localparam int LAT = (NTAPS + 1) / 2 + 4;
  localparam int CNW = $clog2(LAT + 1);
  localparam int PW  = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [PW-1:0]  ph;
  logic [CNW-1:0] cnt;
  logic           run, fourth;

  assign fourth = in_valid && (ph == PW'(DECIM - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0; cnt <= '0; run <= 1'b0;
    end else begin
      if (in_valid) ph <= fourth ? '0 : ph + 1'b1;
      if (fourth) begin
        run <= 1'b1; cnt <= '0;
      end else if (run) begin
        if (cnt == CNW'(LAT)) run <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_left == '0 && out_right == '0));

  // R9
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == CNW'(LAT)) |-> out_valid);

  // R2
  out_when_due_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (run && cnt == CNW'(LAT)));

  // R2
  input_rate_chk: assert property (@(posedge clk) disable iff (rst)
    fourth |-> !run);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));
endmodule

bind fir_dec_top fir_dec_chk #(.NTAPS(NTAPS), .DECIM(DECIM), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right)
);

// File: tb/tb_fir_dec_top.sv
module tb_fir_dec_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 121;
  localparam int MAXS = 2048;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, fsel = 1'b0;
  logic [15:0] in_left = '0, in_right = '0;
  logic out_valid;
  logic [15:0] out_left, out_right;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int xl [MAXS];
  int xr [MAXS];
  int nsamp = 0;
  int exl [512];
  int exr [512];
  int exs [512];
  string ext [512];
  int head = 0, tail = 0;
  string cur_tag = "R1";
  logic [15:0] held_l = '0, held_r = '0;
  int hold_err = 0;
  bit finished = 1'b0;

  fir_dec_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .fsel(fsel), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tb_coef(input bit bank, input int j);
    int h;
    h = (j <= 60) ? j : NT - 1 - j;
    return bank ? 600 - 9 * h : 8 * (h + 1);
  endfunction

  // Rounded, clipped 121-tap reference over stored history (R3 R4 R5 R6)
  function automatic int ref_out(input bit bank, input bit right, input int newest);
    longint acc, q;
    int x;
    acc = 0;
    for (int j = 0; j < NT; j++) begin
      if (newest - j >= 0) begin
        x = right ? xr[newest - j] : xl[newest - j];
        acc += longint'(tb_coef(bank, j)) * longint'(x);
      end
    end
    q = (acc + 64'sd16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives one strobe, then idles.
  task automatic send(input int l, input int r, input int gap);
    in_valid = 1'b1;
    in_left  = 16'(l);
    in_right = 16'(r);
    xl[nsamp] = int'($signed(16'(l)));
    xr[nsamp] = int'($signed(16'(r)));
    nsamp++;
    if (nsamp % 4 == 0) begin
      exl[tail] = ref_out(fsel, 1'b0, nsamp - 1);
      exr[tail] = ref_out(fsel, 1'b1, nsamp - 1);
      exs[tail] = cyc + 1;
      ext[tail] = cur_tag;
      tail++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_valid) begin
        if (head == tail) begin
          check("R2 unexpected out_valid", 1, 0);
        end else begin
          check({ext[head], " left"}, int'($signed(out_left)), exl[head]);
          check({ext[head], "/R8 right"}, int'($signed(out_right)), exr[head]);
          check("R9 latency", cyc - exs[head], 65);
          head++;
        end
        held_l = out_left;
        held_r = out_right;
      end else if (out_left != held_l || out_right != held_r) begin
        hold_err++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1: outputs cleared during reset
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_left in reset", int'(out_left), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_right after reset", int'(out_right), 0);

    // R4: first group sees zero history; R3 impulse response, bank 0
    cur_tag = "R4 warmup";
    send(1000, -2000, 24);
    for (int i = 1; i < 4; i++) send(0, 0, 24);
    cur_tag = "R3 impulse";
    for (int i = 4; i < 128; i++) send(0, 0, 24);

    // R6: full-scale input on bank 1 drives both clip limits
    cur_tag = "R6 clip";
    fsel = 1'b1;
    for (int i = 0; i < 128; i++) send(32767, -32768, 24);

    // R7: bank change after the fourth strobe does not touch that result
    cur_tag = "R7 late select";
    for (int i = 0; i < 3; i++) send(int'($urandom_range(0, 65535)), 1234, 24);
    send(-777, 5000, 5);
    fsel = 1'b0;
    repeat (40) @(negedge clk);
    // R7: change within a group applies to that group's result
    cur_tag = "R7 mid-group select";
    send(300, -300, 24);
    fsel = 1'b1;
    send(-9000, 9000, 24);
    send(20000, 100, 24);
    send(-15000, -100, 24);

    // R3 R5 R8: random samples, random bank, random spacing
    cur_tag = "R5 random";
    for (int i = 0; i < 240; i++) begin
      if (i % 4 == 3 && $urandom_range(0, 3) == 0) fsel = ~fsel;
      send(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
           int'($urandom_range(24, 40)));
    end
    // R3 small-value pattern where rounding dominates
    cur_tag = "R3 small";
    for (int i = 0; i < 132; i++) send(i % 5 - 2, 3 - i % 7, 24);

    repeat (120) @(negedge clk);
    check("R2 output count", head, tail);
    check("R2 outputs per strobes", head, nsamp / 4);
    check("R10 hold between pulses", hold_err, 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule